// File: doc/BRIEF.md
# Dual-Clock Packet FIFO with Rewind

This block is a packet FIFO that sits between two clock domains: a producer side on its own write clock and a consumer side on its own read clock. Data is moved one word per cycle. Each side treats groups of words as packets. A side marks where its current packet begins, commits the packet when it is complete, or abandons it and returns its pointer to the marked start.

On the consumer side, an aborted send rewinds the read pointer, so the same words can be sent again later. On the producer side, a bad packet (for example a failed CRC or a line error) is thrown away by rewinding the write pointer. Only committed progress crosses the clock boundary. The reader never sees words that have not been committed. The writer never reuses space that the reader has read but not yet released.

Each published pointer carries a wrap bit and moves one step per cycle toward the committed value. Its Gray-coded copy therefore changes at most one bit per cycle before it passes through a two-flop synchronizer. The read port is show-ahead: `rd_data` shows the word at the read pointer whenever `rd_empty` is low.

Top module: `pkt_cdc_fifo`

## Requirements
- R1: After reset, `rd_empty`=1, `rd_nonempty`=0 and `wr_full`=0. Every pointer and saved start is zero, so an abort before any start or commit returns the write pointer to address zero.
- R2: Words written and then committed reach `rd_data` in write order. Words that are written but not committed leave `rd_empty` at 1.
- R3: `wr_full` rises once DEPTH words are held that the reader has not released. A write while `wr_full`=1 is ignored.
- R4: `wr_abort` discards every word written since the last saved start. The next committed word follows the previous committed packet directly.
- R5: `wr_start` saves the current write pointer as the packet start. Words written before it are kept by a later abort and are published by the next commit.
- R6: `rd_abort` returns the read pointer to the saved read start, which is set by `rd_start` or by the last `rd_commit`. The same words are then presented again.
- R7: Reading words does not free space for the writer. Only `rd_commit` releases the words read so far, and `wr_full` falls after it.
- R8: When abort and commit are asserted in the same cycle, the abort takes effect and nothing is published.
- R9: `rd_en` while `rd_empty`=1 does not move the read pointer.
- R10: `rd_nonempty` is high exactly when committed, unread data is available, and it is the inverse of `rd_empty`.
- R11: Each published pointer moves one step per cycle, so its Gray copy changes at most one bit per cycle. A full-depth commit becomes entirely readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer active-low reset |
| wr_en | input | 1 | Write one word |
| wr_data | input | DW | Word to write |
| wr_start | input | 1 | Save the write pointer as packet start |
| wr_commit | input | 1 | Publish all writes, including this cycle's |
| wr_abort | input | 1 | Rewind the write pointer to the saved start |
| wr_full | output | 1 | No space left against the reader's released pointer |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer active-low reset |
| rd_en | input | 1 | Consume the shown word |
| rd_start | input | 1 | Save the read pointer as packet start |
| rd_commit | input | 1 | Release all reads, including this cycle's |
| rd_abort | input | 1 | Rewind the read pointer to the saved start |
| rd_data | output | DW | Word at the read pointer (show-ahead) |
| rd_empty | output | 1 | No committed unread word |
| rd_nonempty | output | 1 | Committed data is available |

## Verification
A sweep writes packets of every length from one to DEPTH, twice each, with data computed from the length and index. The pointers wrap several times, so this pattern shows whether ordering and the wrap bit hold. Directed sequences then separate the control cases: writes left uncommitted, an abort after a start, an abort asserted together with a commit, a read-side rewind to a start saved mid-packet, and a full buffer whose reads are not released. In each case the pointer either must or must not have moved, so a wrong priority, an early publish or an early release shows up at the flags or in the data.

// File: rtl/pkt_fifo_pkg.sv
`timescale 1ns/1ps
package pkt_fifo_pkg;
  localparam int PTR_MAX = 16;
  typedef logic [PTR_MAX-1:0] ptr_t;

  function automatic ptr_t bin2gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(input ptr_t g);
    ptr_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // words held between a leading and a trailing pointer (modulo wrap)
  function automatic ptr_t span(input ptr_t lead, input ptr_t trail);
    return lead - trail;
  endfunction
endpackage

// File: rtl/pkt_gray_sync.sv
`timescale 1ns/1ps
module pkt_gray_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pkt_side_ptr.sv
`timescale 1ns/1ps
module pkt_side_ptr
  import pkt_fifo_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          start,
  input  logic          commit,
  input  logic          abort,
  output logic [PW-1:0] cur,
  output logic [PW-1:0] mark,
  output logic [PW-1:0] pub_gray
);
  logic [PW-1:0] cur_adv, cur_n, mark_n, target, pub_bin, pub_n;
  logic          commit_ok;

  assign cur_adv   = cur + PW'(step);
  assign commit_ok = commit && !abort;     // abort wins
  assign cur_n     = abort ? mark : cur_adv;

  always_comb begin
    mark_n = mark;
    if (abort)       mark_n = mark;
    else if (commit) mark_n = cur_adv;
    else if (start)  mark_n = cur;
  end

  // published value chases the committed target one step per cycle
  assign pub_n = (pub_bin != target) ? pub_bin + PW'(1) : pub_bin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      mark     <= '0;
      target   <= '0;
      pub_bin  <= '0;
      pub_gray <= '0;
    end else begin
      cur      <= cur_n;
      mark     <= mark_n;
      if (commit_ok) target <= cur_adv;
      pub_bin  <= pub_n;
      pub_gray <= PW'(bin2gray(ptr_t'(pub_n)));
    end
  end
endmodule

// File: rtl/pkt_cdc_fifo.sv
`timescale 1ns/1ps
module pkt_cdc_fifo
  import pkt_fifo_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_start,
  input  logic          wr_commit,
  input  logic          wr_abort,
  output logic          wr_full,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_en,
  input  logic          rd_start,
  input  logic          rd_commit,
  input  logic          rd_abort,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic          rd_nonempty
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic [PW-1:0] wr_cur, wr_mark, wr_pub_gray, wr_rview, rd_gray_at_wr;
  logic [PW-1:0] rd_cur, rd_mark, rd_pub_gray, rd_wview, wr_gray_at_rd;
  logic          wr_acc, rd_acc;

  // write domain
  assign wr_rview = PW'(gray2bin(ptr_t'(rd_gray_at_wr)));
  assign wr_full  = PW'(span(ptr_t'(wr_cur), ptr_t'(wr_rview))) == PW'(DEPTH);
  assign wr_acc   = wr_en && !wr_full;

  pkt_side_ptr #(.PW(PW)) u_wptr (
    .clk(wr_clk), .rst_n(wr_rst_n), .step(wr_acc), .start(wr_start),
    .commit(wr_commit), .abort(wr_abort),
    .cur(wr_cur), .mark(wr_mark), .pub_gray(wr_pub_gray));

  always_ff @(posedge wr_clk) begin
    if (wr_acc) mem[wr_cur[AW-1:0]] <= wr_data;
  end

  pkt_gray_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_pub_gray), .q(rd_gray_at_wr));

  // read domain
  assign rd_wview    = PW'(gray2bin(ptr_t'(wr_gray_at_rd)));
  assign rd_empty    = rd_cur == rd_wview;
  assign rd_nonempty = !rd_empty;
  assign rd_acc      = rd_en && !rd_empty;
  assign rd_data     = mem[rd_cur[AW-1:0]];

  pkt_side_ptr #(.PW(PW)) u_rptr (
    .clk(rd_clk), .rst_n(rd_rst_n), .step(rd_acc), .start(rd_start),
    .commit(rd_commit), .abort(rd_abort),
    .cur(rd_cur), .mark(rd_mark), .pub_gray(rd_pub_gray));

  pkt_gray_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_pub_gray), .q(wr_gray_at_rd));
endmodule

// File: rtl/pkt_cdc_fifo_chk.sv
`timescale 1ns/1ps
module pkt_cdc_fifo_chk #(
  parameter int AW = 3
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          wr_en,
  input logic          wr_commit,
  input logic          wr_abort,
  input logic          wr_full,
  input logic [AW:0]   wr_cur,
  input logic [AW:0]   wr_mark,
  input logic [AW:0]   wr_rview,
  input logic [AW:0]   wr_pub_gray,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rd_en,
  input logic          rd_abort,
  input logic          rd_empty,
  input logic [AW:0]   rd_cur,
  input logic [AW:0]   rd_mark,
  input logic [AW:0]   rd_wview,
  input logic [AW:0]   rd_pub_gray
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  assert_full_blocks_write_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_full && !wr_abort) |=> $stable(wr_cur));

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (PW'(wr_cur - wr_rview) <= DEPTH_P));

  assert_wr_rewind_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_abort |=> (wr_cur == $past(wr_mark)));

  assert_abort_wins_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_abort && wr_commit) |=> (wr_mark == $past(wr_mark)));

  assert_rd_rewind_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_abort |=> (rd_cur == $past(rd_mark)));

  assert_empty_blocks_read_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_empty && !rd_abort) |=> $stable(rd_cur));

  assert_no_underflow_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (PW'(rd_wview - rd_cur) <= DEPTH_P));

  assert_wr_gray_step_R11: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    ($countones(wr_pub_gray ^ $past(wr_pub_gray)) <= 1));

  assert_rd_gray_step_R11: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    ($countones(rd_pub_gray ^ $past(rd_pub_gray)) <= 1));
endmodule

bind pkt_cdc_fifo pkt_cdc_fifo_chk #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_commit(wr_commit),
  .wr_abort(wr_abort), .wr_full(wr_full), .wr_cur(wr_cur), .wr_mark(wr_mark),
  .wr_rview(wr_rview), .wr_pub_gray(wr_pub_gray),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_abort(rd_abort),
  .rd_empty(rd_empty), .rd_cur(rd_cur), .rd_mark(rd_mark), .rd_wview(rd_wview),
  .rd_pub_gray(rd_pub_gray));

// File: tb/tb_pkt_cdc_fifo.sv
`timescale 1ns/1ps
module tb_pkt_cdc_fifo;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic wr_en = 0, wr_start = 0, wr_commit = 0, wr_abort = 0;
  logic [DW-1:0] wr_data = '0;
  logic rd_en = 0, rd_start = 0, rd_commit = 0, rd_abort = 0;
  logic wr_full, rd_empty, rd_nonempty;
  logic [DW-1:0] rd_data;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 wclk = ~wclk;     // 250 MHz write clock
  always #3.5 rclk = ~rclk;   // independent read clock

  pkt_cdc_fifo #(.DW(DW), .AW(AW)) dut (
    .wr_clk(wclk), .wr_rst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_start(wr_start), .wr_commit(wr_commit), .wr_abort(wr_abort), .wr_full(wr_full),
    .rd_clk(rclk), .rd_rst_n(rrst_n), .rd_en(rd_en), .rd_start(rd_start),
    .rd_commit(rd_commit), .rd_abort(rd_abort), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_nonempty(rd_nonempty));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wcyc(input logic en, input logic [DW-1:0] d,
                      input logic st, input logic cm, input logic ab);
    @(negedge wclk);
    wr_en = en; wr_data = d; wr_start = st; wr_commit = cm; wr_abort = ab;
    @(negedge wclk);
    wr_en = 0; wr_start = 0; wr_commit = 0; wr_abort = 0;
  endtask

  task automatic rcyc(input logic en, input logic st, input logic cm, input logic ab,
                      output logic [DW-1:0] d);
    @(negedge rclk);
    d = rd_data;
    rd_en = en; rd_start = st; rd_commit = cm; rd_abort = ab;
    @(negedge rclk);
    rd_en = 0; rd_start = 0; rd_commit = 0; rd_abort = 0;
  endtask

  task automatic settle();
    repeat (40) @(negedge rclk);
  endtask

  task automatic rexp(input logic [DW-1:0] e, input logic cm, input string tag);
    logic [DW-1:0] d;
    chk(rd_nonempty === 1'b1, tag, rd_nonempty, 1);
    rcyc(1, 0, cm, 0, d);
    chk(d === e, tag, d, e);
  endtask

  initial begin
    logic [DW-1:0] d;
    repeat (4) @(negedge rclk);
    chk(rd_empty === 1'b1, "R1 empty", rd_empty, 1);
    chk(rd_nonempty === 1'b0, "R1 nonempty", rd_nonempty, 0);
    chk(wr_full === 1'b0, "R1 full", wr_full, 0);
    wrst_n = 1; rrst_n = 1;

    // R1: abort straight after reset rewinds to zero
    wcyc(1, 8'h91, 0, 0, 0); wcyc(1, 8'h92, 0, 0, 0);
    wcyc(0, 0, 0, 0, 1);
    // R2: uncommitted words stay invisible
    wcyc(1, 8'h11, 0, 0, 0); wcyc(1, 8'h12, 0, 0, 0); wcyc(1, 8'h13, 0, 0, 0);
    settle();
    chk(rd_empty === 1'b1, "R2 uncommitted hidden", rd_empty, 1);
    wcyc(0, 0, 0, 1, 0);
    settle();
    chk(rd_nonempty === 1'b1, "R10 nonempty after commit", rd_nonempty, 1);
    chk(rd_empty === 1'b0, "R10 empty low", rd_empty, 0);
    rexp(8'h11, 0, "R1 first word at address zero");
    rexp(8'h12, 0, "R2 order");
    rexp(8'h13, 1, "R2 order");
    settle();
    chk(rd_nonempty === 1'b0, "R10 drained", rd_nonempty, 0);

    // R9: read on empty ignored
    rcyc(1, 0, 0, 0, d);
    wcyc(1, 8'h21, 0, 1, 0);
    settle();
    rexp(8'h21, 1, "R9 read on empty ignored");

    // R4/R5: start mid-packet, abort keeps earlier words
    wcyc(1, 8'h31, 0, 0, 0); wcyc(1, 8'h32, 0, 0, 0);
    wcyc(0, 0, 1, 0, 0);
    wcyc(1, 8'h3A, 0, 0, 0); wcyc(1, 8'h3B, 0, 0, 0);
    wcyc(0, 0, 0, 0, 1);
    wcyc(1, 8'h33, 0, 1, 0);
    settle();
    rexp(8'h31, 0, "R5 word before start kept");
    rexp(8'h32, 0, "R5 word before start kept");
    rexp(8'h33, 1, "R4 aborted words discarded");
    settle();
    chk(rd_empty === 1'b1, "R4 nothing extra", rd_empty, 0 + 1);

    // R8: abort and commit together
    wcyc(1, 8'h41, 0, 0, 0); wcyc(1, 8'h42, 0, 0, 0);
    wcyc(0, 0, 0, 1, 1);
    settle();
    chk(rd_empty === 1'b1, "R8 abort beats commit", rd_empty, 1);
    wcyc(1, 8'h43, 0, 1, 0);
    settle();
    rexp(8'h43, 1, "R8 discarded words gone");

    // R6: read rewind to commit point and to a saved start
    wcyc(1, 8'h51, 0, 0, 0); wcyc(1, 8'h52, 0, 0, 0); wcyc(1, 8'h53, 0, 1, 0);
    settle();
    rexp(8'h51, 0, "R6 first pass");
    rexp(8'h52, 0, "R6 first pass");
    rcyc(0, 0, 0, 1, d);
    rexp(8'h51, 0, "R6 rewind to commit point");
    rcyc(0, 1, 0, 0, d);
    rexp(8'h52, 0, "R6 after start");
    rcyc(0, 0, 0, 1, d);
    rexp(8'h52, 0, "R6 rewind to saved start");
    rexp(8'h53, 1, "R6 tail");

    // R3/R7/R11: fill to depth
    for (int i = 0; i < DEPTH; i++) wcyc(1, 8'(8'h60 + i), 0, i == DEPTH - 1, 0);
    settle();
    chk(wr_full === 1'b1, "R3 full at depth", wr_full, 1);
    wcyc(1, 8'hEE, 0, 1, 0);
    settle();
    for (int i = 0; i < DEPTH; i++) rexp(8'(8'h60 + i), 0, "R11 full-depth commit readable");
    chk(rd_empty === 1'b1, "R3 write when full ignored", rd_empty, 1);
    settle();
    chk(wr_full === 1'b1, "R7 reads alone free nothing", wr_full, 1);
    rcyc(0, 0, 1, 0, d);
    settle();
    chk(wr_full === 1'b0, "R7 commit frees space", wr_full, 0);

    // R2 sweep: every length, twice, wrapping pointers
    for (int rep = 0; rep < 2; rep++)
      for (int len = 1; len <= DEPTH; len++) begin
        for (int i = 0; i < len; i++) wcyc(1, 8'(len * 16 + i * 5 + rep * 3), 0, i == len - 1, 0);
        settle();
        for (int i = 0; i < len; i++) rexp(8'(len * 16 + i * 5 + rep * 3), i == len - 1, "R2 sweep");
        chk(rd_empty === 1'b1, "R2 sweep drained", rd_empty, 1);
        settle();
      end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule